// File: doc/BRIEF.md
# Byte-Lane Write-First Dual-Port RAM

This block wraps a single-clock memory that has one write port and one read port. Its storage array behaves read-first: when the read and write ports name the same word on the same clock edge, the array returns the contents that were there before the write. The wrapper detects that case and forwards data past the array, so the registered read result follows write-first rules instead.

Writes are qualified per 8-bit lane of the 32-bit word. On a collision, each lane is resolved separately. A lane whose write enable is set takes the incoming write data. A lane whose enable is clear keeps the array's prior contents. The lane-select bits are registered at the same edge as the array read, and the merge is done on the output side. Read latency is one clock, and the output changes only on edges where the read enable is high.

Top module: `sdpb_wf_ram`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first enabled read, `read_data` is zero.
- R2: A write changes only the 8-bit lanes whose `write_enable` bit is set. Bit i of `write_enable` covers `write_data[8*i+7:8*i]`. Lanes whose bit is clear keep their earlier contents.
- R3: When `read_enable` is high at a rising edge and no collision occurs, `read_data` shows the word stored at `read_addr` from just after that edge.
- R4: When `read_enable` is low at a rising edge, `read_data` keeps its previous value.
- R5: A collision is `read_enable` high, at least one `write_enable` bit set, and `read_addr` equal to `write_addr` at the same edge. If all four enables are set in a collision, `read_data` equals that edge's `write_data`.
- R6: In a collision with a partial enable mask, each enabled lane of `read_data` comes from `write_data`, and each disabled lane comes from the word stored before the write.
- R7: With `write_enable` all zero, a read of an address equal to `write_addr` returns the stored word, and memory is left unchanged.
- R8: A read of a different address than the one being written returns that address's stored word, unaffected by the write data.
- R9: After a colliding write, a later read of that address returns the lane-merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Active-low asynchronous reset of the read-side registers |
| write_enable | input | 4 | Per-lane write strobes, bit i covers byte lane i |
| write_addr | input | ADDR_W | Word address of the write |
| write_data | input | 32 | Write word |
| read_enable | input | 1 | Read strobe; the output updates only when it is high |
| read_addr | input | ADDR_W | Word address of the read |
| read_data | output | 32 | Registered read word with write-first merge |

## Verification
A wrong registered lane-select bit appears as a single wrong byte lane in `read_data` on the cycle right after the colliding edge. It shows up only when the forwarded byte differs from the stored byte. The directed tests therefore always write lane values that differ from the old contents. A lane-select bit that stays set too long would show as write data leaking into a later, non-colliding read. A write-side lane masking error stays hidden until the affected address is read again, so every write test is followed by a read-back of the same word.

// File: rtl/sdpb_pkg.sv
package sdpb_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;   // read accepted this edge
    logic [LANES-1:0] laneSel;   // registered forward selects
  } fwdStrobes_t;
endpackage

// File: rtl/sdpb_storage.sv
module sdpb_storage
  import sdpb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] arrQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // lane-masked write port
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wrEn[l]) mem[wrAddr][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
    end
  end

  // read-first registered read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    arrQ <= '0;
    else if (rdEn) arrQ <= mem[rdAddr];
  end
endmodule

// File: rtl/sdpb_ctrl.sv
module sdpb_ctrl
  import sdpb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output fwdStrobes_t       strobes
);
  logic             addrHit;
  logic [LANES-1:0] laneSelD;
  logic [LANES-1:0] laneSelQ;

  assign addrHit  = rdEn && (|wrEn) && (rdAddr == wrAddr);
  assign laneSelD = addrHit ? wrEn : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    laneSelQ <= '0;
    else if (rdEn) laneSelQ <= laneSelD;
  end

  assign strobes.capture = rdEn;
  assign strobes.laneSel = laneSelQ;

  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> $stable(laneSelQ));

  // R8
  sel_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|laneSelQ) |-> $past(rdEn && (rdAddr == wrAddr)));

  // R6
  sel_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rdEn) |-> ((laneSelQ & ~$past(wrEn)) == '0));
endmodule

// File: rtl/sdpb_datapath.sv
module sdpb_datapath
  import sdpb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fwdStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] arrQ,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] fwdQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               fwdQ <= '0;
    else if (strobes.capture) fwdQ <= wrData;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rdData[l*LANE_W +: LANE_W] = strobes.laneSel[l] ? fwdQ[l*LANE_W +: LANE_W]
                                                           : arrQ[l*LANE_W +: LANE_W];
    // R6
    lane_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes.laneSel[l] && $past(strobes.capture))
        |-> (rdData[l*LANE_W +: LANE_W] == $past(wrData[l*LANE_W +: LANE_W])));
  end

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.capture |=> $stable(rdData));
endmodule

// File: rtl/sdpb_wf_ram.sv
module sdpb_wf_ram
  import sdpb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  write_enable,
  input  logic [ADDR_W-1:0] write_addr,
  input  logic [DATA_W-1:0] write_data,
  input  logic              read_enable,
  input  logic [ADDR_W-1:0] read_addr,
  output logic [DATA_W-1:0] read_data
);
  fwdStrobes_t       strobes;
  logic [DATA_W-1:0] arrQ;

  sdpb_storage #(.ADDR_W(ADDR_W)) i_storage (
    .clk(clk), .rst_n(rst_n), .wrEn(write_enable), .wrAddr(write_addr),
    .wrData(write_data), .rdEn(read_enable), .rdAddr(read_addr), .arrQ(arrQ));

  sdpb_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(write_enable), .wrAddr(write_addr),
    .rdEn(read_enable), .rdAddr(read_addr), .strobes(strobes));

  sdpb_datapath i_datapath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(write_data),
    .arrQ(arrQ), .rdData(read_data));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (read_data == '0));
endmodule

// File: tb/test_sdpb_wf_ram.sv
module test_sdpb_wf_ram;
  localparam int PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    we = '0;
  logic [AW-1:0] wa = '0;
  logic [31:0]   wd = '0;
  logic          re = 1'b0;
  logic [AW-1:0] ra = '0;
  logic [31:0]   rd;

  int errors = 0;
  int checks = 0;
  logic [31:0] modelMem [DEPTH];
  logic [31:0] expOut = '0;

  always #(PERIOD/2) clk = ~clk;

  sdpb_wf_ram #(.ADDR_W(AW)) i_sdpb_wf_ram (
    .clk(clk), .rst_n(rst_n), .write_enable(we), .write_addr(wa),
    .write_data(wd), .read_enable(re), .read_addr(ra), .read_data(rd));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: read_data=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] laneMerge(input logic [31:0] oldW, input logic [31:0] newW,
                                            input logic [3:0] m);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = m[l] ? newW[l*8 +: 8] : oldW[l*8 +: 8];
    return r;
  endfunction

  // one clock: drive at negedge, update the write-first model, check at next negedge
  task automatic step(input logic [3:0] m, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic r, input logic [AW-1:0] b, input string req);
    we = m; wa = a; wd = d; re = r; ra = b;
    if (r) expOut = (a == b) ? laneMerge(modelMem[b], d, m) : modelMem[b];
    modelMem[a] = laneMerge(modelMem[a], d, m);
    @(posedge clk);
    @(negedge clk);
    we = '0; re = 1'b0;
    if (req != "") check(req, rd, expOut);
  endtask

  task automatic fillAll();
    for (int i = 0; i < DEPTH; i++)
      step(4'hF, AW'(i), 32'hA5000000 | 32'(i * 32'h0101), 1'b0, '0, "");
  endtask

  task automatic testReset();
    check("R1", rd, 32'h0);
    step(4'hF, 6'd3, 32'h11223344, 1'b0, '0, "R1");
  endtask

  task automatic testPlainRead();
    step('0, '0, '0, 1'b1, 6'd5, "R3");
    step('0, '0, '0, 1'b1, 6'd63, "R3");
  endtask

  task automatic testLaneWrite();
    step(4'b0101, 6'd7, 32'hDEADBEEF, 1'b0, '0, "");
    step('0, '0, '0, 1'b1, 6'd7, "R2");
    step(4'b1000, 6'd8, 32'h77000000, 1'b0, '0, "");
    step('0, '0, '0, 1'b1, 6'd8, "R2");
  endtask

  task automatic testHold();
    step('0, '0, '0, 1'b1, 6'd10, "R3");
    step(4'hF, 6'd10, 32'h0BADF00D, 1'b0, 6'd10, "R4");
    step('0, '0, '0, 1'b0, 6'd20, "R4");
  endtask

  task automatic testCollisions();
    step(4'hF, 6'd12, 32'hCAFEBABE, 1'b1, 6'd12, "R5");
    step(4'b0010, 6'd13, 32'h12345678, 1'b1, 6'd13, "R6");
    step(4'b1001, 6'd14, 32'h9ABCDEF0, 1'b1, 6'd14, "R6");
    step('0, '0, '0, 1'b1, 6'd13, "R9");
    step('0, '0, '0, 1'b1, 6'd14, "R9");
  endtask

  task automatic testNoEnable();
    step(4'h0, 6'd15, 32'hFFFFFFFF, 1'b1, 6'd15, "R7");
    step('0, '0, '0, 1'b1, 6'd15, "R7");
  endtask

  task automatic testOtherAddr();
    step(4'hF, 6'd16, 32'h55AA55AA, 1'b1, 6'd17, "R8");
    step('0, '0, '0, 1'b1, 6'd16, "R8");
  endtask

  task automatic testRandom();
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [AW-1:0] b;
      a = AW'($urandom_range(0, 7));
      b = ($urandom_range(0, 2) != 0) ? a : AW'($urandom_range(0, 7));
      step(4'($urandom), a, $urandom, 1'($urandom_range(0, 3) != 0), b, "R6");
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: read_data=%h expected=finish", rd);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) modelMem[i] = 'x;
    repeat (3) @(negedge clk);
    check("R1", rd, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    fillAll();
    testPlainRead();
    testLaneWrite();
    testHold();
    testCollisions();
    testNoEnable();
    testOtherAddr();
    testRandom();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule